// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that software reaches over a small 32-bit register bus. A 16-bit counter counts upward from a start value that software loads. It advances once every N timer ticks, where N is one of eight divide ratios. When it wraps from 0xFFFF to 0x0000 the block sets a sticky overflow flag and drives a reset request, stretched to a fixed pulse, toward the system reset logic. That reset does not clear the block's own state. After the restart, software can read the flag and learn that the watchdog fired.

Every write must carry a key in its upper bits, and the counter's key differs from the control registers' key. This makes a stray store unlikely to disturb the watchdog. A counter write does not load at once. It is carried into the counting side over two timer ticks, and a read-only pending flag shows this. Software polls that flag before it sets the enable bit. Software services the watchdog by writing a new start value. To force an immediate reset, software writes 0xFFFF while the timer is enabled.

The timer clock arrives as a one-cycle tick strobe that is synchronous to the bus clock. Word offsets are 0x0 for the counter, 0x4 for control A and 0x8 for control B.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset every register reads zero (counter, control A, control B) and the reset request is low. A counter write that is still pending when reset arrives is discarded.
- R2: A write to offset 0x0 whose bits 31:16 equal 0x5A5A loads bits 15:0 into the counter on the second timer tick after the write. Until then, reads of offset 0x0 return the old count.
- R3: A write whose key field is wrong is ignored, and no register changes. For the counter the key field is bits 31:16; for the control registers it is bits 31:8. Writes with address bits 1:0 not zero are also ignored.
- R4: A write to offset 0x4 or 0x8 whose bits 31:8 equal 0xA5A5A5 takes its payload from bits 7:0. Offset 0x8 reads back all eight payload bits. Offset 0x4 reads back bit 7 (enable) and bits 2:0 (divide select); bits 6 and 3 read as zero.
- R5: Control A bit 5 reads 1 from the accepted counter write until the second timer tick after it. Writes to that bit have no effect.
- R6: The counter advances only while control A bit 7 is 1. When the bit is cleared, the count is held.
- R7: Control A bits 2:0 with values 0 to 7 select one count step per 1, 4, 16, 32, 64, 128, 1024 or 4096 timer ticks. A keyed control A write restarts the division.
- R8: A count step taken at 0xFFFF wraps the counter to 0x0000, sets control A bit 4, and raises the reset request in the next cycle for exactly 16 bus clock cycles. An overflow during an active pulse does not extend the pulse.
- R9: Control A bit 4 is sticky, and the counter keeps counting after an overflow. Writing 1 to bit 4 does not set it. Only a keyed control A write with bit 4 equal to 0, or reset, clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is clocked here |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| tmr_tick | input | 1 | One-cycle timer tick strobe, synchronous to clk |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write enable (with bus_sel) |
| bus_addr | input | ADDR_W (4) | Byte address |
| bus_wdata | input | 32 | Write data with key field |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdt_reset_req | output | 1 | Stretched reset request pulse |

## Verification
The bench builds the block with its default parameters: a 12-bit prescaler, a two-tick pending window and a 16-cycle reset pulse. With these values the largest divide ratio (4096 ticks) fits in a few thousand cycles, and the whole pulse width can be counted cycle by cycle. The bench drives the timer tick itself, so it knows the exact tick on which a count step or a pending load falls. This lets it check the old count before the second tick, and the wrap and flag on the overflowing step. A reset during a pending load shows that the load is dropped.

// File: rtl/wdt_keyed_pkg.sv
// Shared constants and helpers for the keyed watchdog.
// Assumes a 32-bit data word whose lower half holds the counter.
package wdt_keyed_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = WORD_W / 2;

    // Returns log2 of the divide ratio picked by a 3-bit select.
    function automatic logic [3:0] div_shift(input logic [2:0] s);
        case (s)
            3'd0:    div_shift = 4'd0;
            3'd1:    div_shift = 4'd2;
            3'd2:    div_shift = 4'd4;
            3'd3:    div_shift = 4'd5;
            3'd4:    div_shift = 4'd6;
            3'd5:    div_shift = 4'd7;
            3'd6:    div_shift = 4'd10;
            default: div_shift = 4'd12;
        endcase
    endfunction

endpackage

// File: rtl/wdt_regif.sv
// Register interface: checks write keys and alignment, holds the control
// fields, and builds the read word.
// Assumes the read data is sampled combinationally by the bus master.
module wdt_regif
    import wdt_keyed_pkg::*;
#(
    parameter int          ADDR_W  = 4,
    parameter logic [15:0] CNT_KEY = 16'h5A5A,
    parameter logic [23:0] CTL_KEY = 24'hA5A5A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              pend,
    input  logic              ovf,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wr_val,
    output logic              ctla_wr,
    output logic              ovf_clr,
    output logic              en_q,
    output logic [2:0]        sel_q,
    output logic [WORD_W-1:0] bus_rdata
);
    localparam int WIX_W = ADDR_W - 2;

    logic [WIX_W-1:0] word;
    logic             wr_go;
    logic             ctlb_wr;
    logic [7:0]       aux_q;

    // Decodes word index and the keyed write strobes.
    always_comb begin
        word       = bus_addr[ADDR_W-1:2];
        wr_go      = bus_sel && bus_we && (bus_addr[1:0] == 2'b00);
        cnt_wr     = wr_go && (word == WIX_W'(0)) && (bus_wdata[31:16] == CNT_KEY);
        ctla_wr    = wr_go && (word == WIX_W'(1)) && (bus_wdata[31:8] == CTL_KEY);
        ctlb_wr    = wr_go && (word == WIX_W'(2)) && (bus_wdata[31:8] == CTL_KEY);
        ovf_clr    = ctla_wr && !bus_wdata[4];
        cnt_wr_val = bus_wdata[CNT_W-1:0];
    end

    // Stores enable, divide select and the second control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= 3'd0;
            aux_q <= 8'd0;
        end else begin
            if (ctla_wr) begin
                en_q  <= bus_wdata[7];
                sel_q <= bus_wdata[2:0];
            end
            if (ctlb_wr) begin
                aux_q <= bus_wdata[7:0];
            end
        end
    end

    // Builds the read word for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (word == WIX_W'(0)) begin
            bus_rdata[CNT_W-1:0] = cnt_val;
        end else if (word == WIX_W'(1)) begin
            bus_rdata[7:0] = {en_q, 1'b0, pend, ovf, 1'b0, sel_q};
        end else if (word == WIX_W'(2)) begin
            bus_rdata[7:0] = aux_q;
        end
    end

endmodule

// File: rtl/wdt_prescaler.sv
// Divides the timer tick by 1..4096 and emits one count step per period.
// Assumes PRE_W is at least 12 so that the largest ratio fits.
module wdt_prescaler
    import wdt_keyed_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] sel,
    output logic       step
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    // Derives the terminal count and the step strobe.
    always_comb begin
        lim  = PRE_W'((32'd1 << div_shift(sel)) - 32'd1);
        step = tick && run && (pre_q == lim);
    end

    // Advances the tick divider; cleared while stopped or reconfigured.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= step ? '0 : pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_counter.sv
// Up-counter with a tick-timed load path and the sticky overflow flag.
// Assumes PEND_TICKS >= 1; a new write restarts a pending load.
module wdt_counter
    import wdt_keyed_pkg::*;
#(
    parameter int PEND_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             step,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             pend,
    output logic             ovf_q,
    output logic             ovf_evt
);
    localparam int PD_W = $clog2(PEND_TICKS + 1);

    logic [PD_W-1:0]  pd_q;
    logic [CNT_W-1:0] hold_q;
    logic             load;

    // Flags the load tick and the wrap event.
    always_comb begin
        pend    = (pd_q != '0);
        load    = tick && (pd_q == PD_W'(1)) && !wr;
        ovf_evt = step && (&cnt_q);
    end

    // Captures written value and times the pending window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q   <= '0;
            hold_q <= '0;
        end else if (wr) begin
            pd_q   <= PD_W'(PEND_TICKS);
            hold_q <= wr_val;
        end else if (tick && pend) begin
            pd_q   <= pd_q - 1'b1;
        end
    end

    // Loads or advances the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= hold_q;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Keeps the overflow flag until an explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (ovf_evt) begin
            ovf_q <= 1'b1;
        end else if (ovf_clr) begin
            ovf_q <= 1'b0;
        end
    end

endmodule

// File: rtl/wdt_rst_pulse.sv
// Stretches an overflow event into a fixed-length reset request.
// Assumes events during an active pulse are dropped.
module wdt_rst_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic req
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left_q;

    // Loads the pulse length on an idle event and counts it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (evt && left_q == '0) begin
            left_q <= PW'(PULSE_LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Drives the request while cycles remain.
    assign req = (left_q != '0);

endmodule

// File: rtl/wdt_keyed_top.sv
// Top of the keyed watchdog: register interface, prescaler, counter and
// reset pulse stretcher. Assumes tmr_tick is synchronous to clk.
module wdt_keyed_top
    import wdt_keyed_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter int          PRE_W      = 12,
    parameter int          PEND_TICKS = 2,
    parameter int          PULSE_LEN  = 16,
    parameter logic [15:0] CNT_KEY    = 16'h5A5A,
    parameter logic [23:0] CTL_KEY    = 24'hA5A5A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_reset_req
);
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_wr_val;
    logic             ctla_wr;
    logic             ovf_clr;
    logic             en_q;
    logic [2:0]       sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend;
    logic             ovf_q;
    logic             ovf_evt;
    logic             step;
    logic             run;

    // Counting is allowed only when enabled and no load is in flight.
    assign run = en_q && !pend;

    wdt_regif #(.ADDR_W(ADDR_W), .CNT_KEY(CNT_KEY), .CTL_KEY(CTL_KEY)) u_regif (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_val(cnt_q),
        .pend(pend), .ovf(ovf_q), .cnt_wr(cnt_wr), .cnt_wr_val(cnt_wr_val),
        .ctla_wr(ctla_wr), .ovf_clr(ovf_clr), .en_q(en_q), .sel_q(sel_q),
        .bus_rdata(bus_rdata)
    );

    wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tmr_tick), .run(run),
        .restart(ctla_wr), .sel(sel_q), .step(step)
    );

    wdt_counter #(.PEND_TICKS(PEND_TICKS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tmr_tick), .step(step), .wr(cnt_wr),
        .wr_val(cnt_wr_val), .ovf_clr(ovf_clr), .cnt_q(cnt_q), .pend(pend),
        .ovf_q(ovf_q), .ovf_evt(ovf_evt)
    );

    wdt_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .evt(ovf_evt), .req(wdt_reset_req)
    );

endmodule

// File: rtl/wdt_keyed_chk.sv
// Property checker for the keyed watchdog, bound into the top module.
module wdt_keyed_chk #(
    parameter int          ADDR_W    = 4,
    parameter int          PULSE_LEN = 16,
    parameter logic [15:0] CNT_KEY   = 16'h5A5A,
    parameter logic [23:0] CTL_KEY   = 24'hA5A5A5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [15:0]       cnt_q,
    input logic              step,
    input logic              ovf_q,
    input logic              en_q,
    input logic [2:0]        sel_q,
    input logic              pend,
    input logic              wdt_reset_req
);
    localparam int HW = $clog2(PULSE_LEN + 2);

    logic [HW-1:0] hi_len;
    logic          wr_a;
    logic          wr_c;

    // Recognises aligned writes to counter and control A.
    assign wr_c = bus_sel && bus_we && bus_addr == ADDR_W'(0);
    assign wr_a = bus_sel && bus_we && bus_addr == ADDR_W'(4);

    // Counts consecutive cycles of the reset request.
    always_ff @(posedge clk) begin
        if (!rst_n || !wdt_reset_req) hi_len <= '0;
        else if (hi_len != '1)       hi_len <= hi_len + 1'b1;
    end

    a_r8_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == 16'hFFFF) |=> (ovf_q && cnt_q == 16'h0000));

    a_r8_req_follows_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == 16'hFFFF && !wdt_reset_req) |=> wdt_reset_req);

    a_r8_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_req |-> (int'(hi_len) < PULSE_LEN));

    a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !pend) |=> $stable(cnt_q));

    a_r3_bad_ctl_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && bus_wdata[31:8] != CTL_KEY) |=> ($stable(en_q) && $stable(sel_q)));

    a_r5_pend_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && bus_wdata[31:16] == CNT_KEY) |=> pend);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(wr_a && bus_wdata[31:8] == CTL_KEY && !bus_wdata[4])) |=> ovf_q);

endmodule

bind wdt_keyed_top wdt_keyed_chk #(
    .ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN), .CNT_KEY(CNT_KEY), .CTL_KEY(CTL_KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_q(cnt_q), .step(step),
    .ovf_q(ovf_q), .en_q(en_q), .sel_q(sel_q), .pend(pend),
    .wdt_reset_req(wdt_reset_req)
);

// File: tb/tb_wdt_keyed_top.sv
module tb_wdt_keyed_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        wdt_reset_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wdt_keyed_top dut (
        .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_reset_req(wdt_reset_req)
    );

    typedef struct packed {
        logic        we;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [15:0] ticks;
        logic [3:0]  chk;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'h0, 32'h5A5A1234, 16'd0,  4'h4, 32'h20,   8'd5}, // R5 pending set
        '{1'b0, 4'h0, 32'h0,        16'd1,  4'h0, 32'h0,    8'd2}, // R2 old value
        '{1'b0, 4'h0, 32'h0,        16'd0,  4'h4, 32'h20,   8'd5}, // R5 still pending
        '{1'b0, 4'h0, 32'h0,        16'd1,  4'h0, 32'h1234, 8'd2}, // R2 loaded
        '{1'b0, 4'h0, 32'h0,        16'd0,  4'h4, 32'h00,   8'd5}, // R5 cleared
        '{1'b1, 4'h0, 32'h5A5B0077, 16'd3,  4'h0, 32'h1234, 8'd3}, // R3 bad counter key
        '{1'b1, 4'h4, 32'hA5A5A487, 16'd0,  4'h4, 32'h00,   8'd3}, // R3 bad control key
        '{1'b1, 4'h4, 32'hA5A5A580, 16'd3,  4'h0, 32'h1237, 8'd6}, // R6 enabled div1
        '{1'b1, 4'h4, 32'hA5A5A500, 16'd5,  4'h0, 32'h1237, 8'd6}, // R6 disabled holds
        '{1'b1, 4'h8, 32'hA5A5A5C3, 16'd0,  4'h8, 32'hC3,   8'd4}, // R4 control B
        '{1'b1, 4'h8, 32'h12A5A5FF, 16'd0,  4'h8, 32'hC3,   8'd3}, // R3 bad key B
        '{1'b1, 4'h4, 32'hA5A5A581, 16'd7,  4'h0, 32'h1238, 8'd7}, // R7 div4
        '{1'b0, 4'h0, 32'h0,        16'd1,  4'h0, 32'h1239, 8'd7}, // R7 div4 second
        '{1'b1, 4'h4, 32'hA5A5A582, 16'd16, 4'h0, 32'h123A, 8'd7}, // R7 div16
        '{1'b1, 4'h4, 32'hA5A5A503, 16'd0,  4'h4, 32'h03,   8'd4}, // R4 readback
        '{1'b1, 4'h4, 32'hA5A5A5B3, 16'd32, 4'h0, 32'h123B, 8'd7}, // R7 div32
        '{1'b0, 4'h0, 32'h0,        16'd0,  4'h4, 32'h83,   8'd9}  // R9 R5 bits not set
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tmr_tick = 1'b1;
            repeat (n) @(negedge clk);
            tmr_tick = 1'b0;
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R0: watchdog expired, got 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); check("R1 counter", v, 32'h0);
        rd(4'h4, v); check("R1 ctrlA", v, 32'h0);
        rd(4'h8, v); check("R1 ctrlB", v, 32'h0);
        check("R1 req", {31'd0, wdt_reset_req}, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we) wr(VEC[i].addr, VEC[i].wdata);
            ticks(int'(VEC[i].ticks));
            rd(VEC[i].chk, v);
            checks++;
            if (v !== VEC[i].exp) begin
                fails++;
                $display("FAIL R%0d (row %0d): got %h expected %h", VEC[i].req, i, v, VEC[i].exp);
            end
        end

        // R7 large ratios
        wr(4'h4, 32'hA5A5A586);
        ticks(1023); rd(4'h0, v); check("R7 div1024 early", v, 32'h123B);
        ticks(1);    rd(4'h0, v); check("R7 div1024 step", v, 32'h123C);
        wr(4'h4, 32'hA5A5A587);
        ticks(4095); rd(4'h0, v); check("R7 div4096 early", v, 32'h123C);
        ticks(1);    rd(4'h0, v); check("R7 div4096 step", v, 32'h123D);

        // R3 misaligned write ignored
        wr(4'h5, 32'hA5A5A500);
        rd(4'h4, v); check("R3 misaligned", v, 32'h87);

        // R8 overflow from 0xFFFF
        wr(4'h4, 32'hA5A5A500);
        wr(4'h0, 32'h5A5AFFFF);
        ticks(2);
        rd(4'h0, v); check("R2 load FFFF", v, 32'hFFFF);
        rd(4'h4, v); check("R5 done", v, 32'h00);
        wr(4'h4, 32'hA5A5A580);
        check("R8 req idle", {31'd0, wdt_reset_req}, 32'h0);
        ticks(1);
        check("R8 req raised", {31'd0, wdt_reset_req}, 32'h1);
        rd(4'h4, v); check("R8 flag set", v, 32'h90);
        rd(4'h0, v); check("R8 wrap", v, 32'h0);
        hi = 0;
        while (wdt_reset_req && hi < 100) begin
            hi++;
            @(negedge clk);
        end
        check("R8 pulse width", 32'(hi), 32'd16);

        // R9 sticky flag and continued counting
        ticks(1);
        rd(4'h0, v); check("R9 counts on", v, 32'h1);
        wr(4'h4, 32'hA5A5A590);
        rd(4'h4, v); check("R9 write 1 keeps", v, 32'h90);
        wr(4'h4, 32'h00A5A580);
        rd(4'h4, v); check("R3 bad key no clear", v, 32'h90);
        wr(4'h4, 32'hA5A5A580);
        rd(4'h4, v); check("R9 keyed clear", v, 32'h80);

        // R1 reset mid-operation discards pending load
        wr(4'h0, 32'h5A5A0042);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(4'h4, v); check("R1 ctrlA after reset", v, 32'h0);
        ticks(2);
        rd(4'h0, v); check("R1 pending dropped", v, 32'h0);
        check("R1 req after reset", {31'd0, wdt_reset_req}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule